// File: doc/BRIEF.md
# Processor interrupt pin front-end

This block sits between the external control pins of a processor core and the core's exception logic. It watches six pins: external interrupt, system management interrupt, machine check, checkstop input, hard reset and soft reset. Each pin first passes through a two-flop synchronizer. The block then compares the synchronized level with the level it last accepted. Only a real change causes an action. A steady pin, however long it is held, is never re-applied.

Each pin has its own sensitivity. The interrupt-style pins and soft reset are active-high levels that set and clear a pending bit. Machine check is sensitive to the falling edge and can only set its bit. Checkstop and hard reset are active-low levels that drive the halt and reset outputs. A single interrupt request goes to the core whenever any pending bit is set. The core acknowledges work by pulsing a clear strobe with a bit mask. The pin vector can be wider than six bits, and the pin positions above the known six are ignored.

Top module: `irq_pin_frontend`

## Requirements
- R1: If the synchronized level of a pin equals its last accepted level, no pending bit and no control output changes. The accepted level is updated on every clock, so a level that is held, or that is re-applied after an acknowledge, does not re-trigger.
- R2: Pin bit 0 (external interrupt) and pin bit 1 (system management) are active high. On a change, pending bit 0 or pending bit 1 takes the new pin level: it is set on high and cleared on low.
- R3: Pin bit 2 (machine check) sets pending bit 2 on a 1-to-0 transition. A 0-to-1 transition leaves pending bit 2 unchanged.
- R4: Pin bit 3 (checkstop, active low) drives `halt_o`. A change to low raises `halt_o`, and a change back to high lowers it.
- R5: Pin bit 4 (hard reset, active low) drives `core_reset_o`. A change to low raises `core_reset_o`, and a change back to high lowers it.
- R6: Pin bit 5 (soft reset) is active high. On a change, pending bit 3 takes the new pin level.
- R7: `irq_o` is high exactly when at least one pending bit is set.
- R8: Pin positions 6 and above have no effect on any output.
- R9: When `ack_valid_i` is high at a clock edge, each pending bit selected by `ack_mask_i` clears at that edge.
- R10: If a pin event sets a pending bit at the same edge that an acknowledge clears it, the bit ends up set.
- R11: A pin change that is present before rising edge k shows on the outputs after rising edge k+2. After reset, pending bits, `irq_o`, `halt_o` and `core_reset_o` are all 0, and checkstop and hard reset are taken as idle-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Raw pin levels; bits 0 to 5 are assigned, higher bits are ignored |
| ack_valid_i | input | 1 | Acknowledge strobe from the core |
| ack_mask_i | input | 4 | Pending bits to clear when the strobe is high |
| pending_o | output | 4 | Pending bits: 0 external, 1 system management, 2 machine check, 3 soft reset |
| irq_o | output | 1 | Interrupt request to the core |
| halt_o | output | 1 | Stop the core (checkstop asserted) |
| core_reset_o | output | 1 | Reset the core (hard reset asserted) |

## Verification
The bench builds the block with NUM_PINS = 8. This leaves two unassigned pin positions, which the stimulus toggles freely to show that they never reach an output. With only four pending bits, random acknowledge masks often land on the same edge as a pin event. This makes the set-over-clear conflict, and the case of an acknowledge followed by a pin that is still held, occur many times. The reference model follows each pin through the synchronizer delay so that the outputs can be compared on every clock.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam int PIN_EXT    = 0;
  localparam int PIN_SMI    = 1;
  localparam int PIN_MCHK   = 2;
  localparam int PIN_CKSTOP = 3;
  localparam int PIN_HRESET = 4;
  localparam int PIN_SRESET = 5;
  localparam int NUM_KNOWN  = 6;

  localparam int SRC_EXT  = 0;
  localparam int SRC_SMI  = 1;
  localparam int SRC_MCHK = 2;
  localparam int SRC_SRST = 3;
  localparam int NUM_SRC  = 4;

  // idle level of the known pins: active-low controls rest high
  localparam logic [NUM_KNOWN-1:0] KNOWN_IDLE = 6'b011000;

  function automatic int src_pin(int src);
    case (src)
      SRC_EXT:  return PIN_EXT;
      SRC_SMI:  return PIN_SMI;
      SRC_MCHK: return PIN_MCHK;
      default:  return PIN_SRESET;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int               W       = 8,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_change_det.sv
module irq_change_det #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] chg_o,
  output logic [W-1:0] last_o
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= RST_VAL;
    else         last_q <= lvl_i;
  end

  assign chg_o  = lvl_i ^ last_q;
  assign last_o = last_q;

  // R1: accepted level tracks the synchronized level
  a_r1_level_tracked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> last_q == $past(lvl_i));
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_fe_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] chg_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic                ack_valid_i,
  input  logic [NUM_SRC-1:0]  ack_mask_i,
  output logic [NUM_SRC-1:0]  pend_o
);
  logic [NUM_SRC-1:0] set_v, lvl_clr_v, clr_v, pend_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int P = src_pin(s);
    if (s == SRC_MCHK) begin : g_fall
      assign set_v[s]     = chg_i[P] & ~lvl_i[P];
      assign lvl_clr_v[s] = 1'b0;
    end else begin : g_level
      assign set_v[s]     = chg_i[P] & lvl_i[P];
      assign lvl_clr_v[s] = chg_i[P] & ~lvl_i[P];
    end
    assign clr_v[s] = lvl_clr_v[s] | (ack_valid_i & ack_mask_i[s]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_v) | set_v; // set wins
  end

  assign pend_o = pend_q;

  a_r1_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i[NUM_KNOWN-1:0] == '0 && !ack_valid_i) |=> pend_q == $past(pend_q));

  a_r2_ext_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i[PIN_EXT] |=> pend_q[SRC_EXT] == $past(lvl_i[PIN_EXT]));

  a_r3_rise_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i[PIN_MCHK] && lvl_i[PIN_MCHK] && !pend_q[SRC_MCHK]) |=> !pend_q[SRC_MCHK]);

  a_r8_unknown_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i[NUM_PINS-1:NUM_KNOWN] != '0 && chg_i[NUM_KNOWN-1:0] == '0 && !ack_valid_i)
      |=> pend_q == $past(pend_q));

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && ack_mask_i[SRC_SRST] && !(chg_i[PIN_SRESET] && lvl_i[PIN_SRESET]))
      |=> !pend_q[SRC_SRST]);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i[PIN_SRESET] && lvl_i[PIN_SRESET]) |=> pend_q[SRC_SRST]);
endmodule

// File: rtl/irq_pin_frontend.sv
module irq_pin_frontend
  import irq_fe_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                ack_valid_i,
  input  logic [NUM_SRC-1:0]  ack_mask_i,
  output logic [NUM_SRC-1:0]  pending_o,
  output logic                irq_o,
  output logic                halt_o,
  output logic                core_reset_o
);
  localparam logic [NUM_PINS-1:0] IDLE = NUM_PINS'(KNOWN_IDLE);

  logic [NUM_PINS-1:0] sync_lvl, chg, last_lvl;

  irq_sync #(.W(NUM_PINS), .RST_VAL(IDLE)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(sync_lvl)
  );

  irq_change_det #(.W(NUM_PINS), .RST_VAL(IDLE)) u_chg (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl), .chg_o(chg), .last_o(last_lvl)
  );

  irq_pending #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .chg_i(chg), .lvl_i(sync_lvl),
    .ack_valid_i(ack_valid_i), .ack_mask_i(ack_mask_i), .pend_o(pending_o)
  );

  assign irq_o        = |pending_o;
  assign halt_o       = ~last_lvl[PIN_CKSTOP];
  assign core_reset_o = ~last_lvl[PIN_HRESET];

  a_r4_halt_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg[PIN_CKSTOP] |=> halt_o == !$past(sync_lvl[PIN_CKSTOP]));

  a_r5_reset_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg[PIN_HRESET] |=> core_reset_o == !$past(sync_lvl[PIN_HRESET]));

  a_r7_irq_drops_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o == '0 && chg[NUM_KNOWN-1:0] == '0) |=> !irq_o);
endmodule

// File: tb/irq_pin_frontend_tb.sv
module irq_pin_frontend_tb;
  localparam int NP = 8;
  localparam logic [NP-1:0] IDLE = 8'b0001_1000;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pins = IDLE;
  logic          ack_v = 1'b0;
  logic [3:0]    ack_m = '0;
  logic [3:0]    pend;
  logic          irq, halt, creset;

  int vectors = 0, fails = 0, cyc = 0;
  string phase = "R11 reset";

  always #5 clk = ~clk;

  irq_pin_frontend #(.NUM_PINS(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .ack_valid_i(ack_v),
    .ack_mask_i(ack_m), .pending_o(pend), .irq_o(irq), .halt_o(halt),
    .core_reset_o(creset)
  );

  // behavioural reference: queue of pin samples models synchronizer delay
  logic [5:0] q_pins[$];
  logic [5:0] m_last;
  logic [3:0] m_pend;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_pins = {IDLE[5:0], IDLE[5:0]};
      m_last = IDLE[5:0];
      m_pend = '0;
    end else begin
      logic [5:0] now;
      logic [3:0] setf, clrf;
      now  = q_pins.pop_front();
      setf = '0; clrf = '0;
      if (now[0] != m_last[0]) begin if (now[0]) setf[0] = 1; else clrf[0] = 1; end
      if (now[1] != m_last[1]) begin if (now[1]) setf[1] = 1; else clrf[1] = 1; end
      if (now[2] != m_last[2] && !now[2]) setf[2] = 1;
      if (now[5] != m_last[5]) begin if (now[5]) setf[3] = 1; else clrf[3] = 1; end
      if (ack_v) clrf = clrf | ack_m;
      m_pend = (m_pend & ~clrf) | setf;
      m_last = now;
      q_pins.push_back(pins[5:0]);
    end
  end

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("pending", pend, m_pend);
    chk("irq R7", irq, (m_pend != 0));
    chk("halt R4", halt, !m_last[3]);
    chk("core_reset R5", creset, !m_last[4]);
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog R11 act=running exp=finished");
      summary();
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(2);
    chk("R11 reset pending", pend, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset halt", halt, 0);
    chk("R11 reset core_reset", creset, 0);
    rst_n = 1'b1;
    wait_n(3);

    phase = "R2 R11 level pins";
    pins[0] = 1; wait_n(2);
    chk("R11 not yet", pend[0], 0);
    wait_n(1);
    chk("R11 at third edge", pend[0], 1);
    pins[1] = 1; wait_n(4);
    pins[0] = 0; wait_n(4);
    pins[1] = 0; wait_n(4);

    phase = "R3 machine check edge";
    pins[2] = 1; wait_n(4);
    chk("R3 rise ignored", pend[2], 0);
    pins[2] = 0; wait_n(4);
    chk("R3 fall sets", pend[2], 1);
    ack_v = 1; ack_m = 4'b0100; wait_n(1); ack_v = 0; ack_m = 0;
    wait_n(3);

    phase = "R4 checkstop";
    pins[3] = 0; wait_n(4); chk("R4 halt", halt, 1);
    pins[3] = 1; wait_n(4); chk("R4 restart", halt, 0);

    phase = "R5 hard reset";
    pins[4] = 0; wait_n(4); chk("R5 reset", creset, 1);
    pins[4] = 1; wait_n(4);

    phase = "R6 soft reset";
    pins[5] = 1; wait_n(4); chk("R6 set", pend[3], 1);
    pins[5] = 0; wait_n(4); chk("R6 clear", pend[3], 0);

    phase = "R9 R1 ack while held";
    pins[0] = 1; wait_n(4);
    ack_v = 1; ack_m = 4'b0001; wait_n(1); ack_v = 0; ack_m = 0;
    wait_n(4);
    chk("R1 held pin no retrigger", pend[0], 0);
    pins[0] = 0; wait_n(4);

    phase = "R10 set beats ack";
    pins[5] = 1; wait_n(2);
    ack_v = 1; ack_m = 4'b1111; wait_n(1); ack_v = 0; ack_m = 0;
    wait_n(1);
    chk("R10 set wins", pend[3], 1);
    pins[5] = 0; wait_n(4);

    phase = "R8 unknown pins";
    for (int i = 0; i < 6; i++) begin pins[7:6] = 2'(i); wait_n(2); end
    wait_n(3);
    chk("R8 no effect", {pend, irq, halt, creset}, 0);

    phase = "R1 R2 R3 R4 R5 R6 R7 R9 R10 random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) pins = pins ^ NP'($urandom_range(255));
      ack_v = ($urandom_range(3) == 0);
      ack_m = 4'($urandom_range(15));
      wait_n(1);
    end
    ack_v = 0;
    wait_n(5);
    summary();
  end
endmodule